// File: doc/BRIEF.md
# Greyscale Scan-Out Expander

The block turns a nibble-packed greyscale display memory into a magnified RGB565 pixel stream for a downstream display sink. Each memory byte holds two 4-bit grey levels. The block walks the visible part of the memory line by line. It shows every source pixel several times across and every source line several times down. It widens each grey level into a 16-bit colour word in which red, green and blue carry the same intensity. With the default parameters, 64 source rows of 64 bytes become a 512 x 256 output frame. The memory behind it is 80 rows deep, so its last 16 rows are never shown.

A single-cycle redraw request sets an internal dirty flag. While the flag is set and no frame is running, the block starts a frame. It issues reads on a synchronous memory port with one cycle of latency. It delivers pixels over a valid/ready handshake with a start-of-frame marker and an end-of-line marker. The flag clears when the sink accepts the final pixel of the frame. While the sink holds ready low the block stalls, and when ready stays high it sustains one pixel per clock.

Top module: `grey_scanout`

## Requirements
- R1: After synchronous reset, `pix_valid_o`, `ram_rd_en_o` and `redraw_flag_o` are all 0.
- R2: While `redraw_flag_o` is 0, and no frame is in progress, the block issues no memory reads and presents no pixels. A frame starts only after `redraw_set_i` has set the flag.
- R3: A frame issues exactly ROWS x MAG x BYTES reads. Read number k uses the address (k / BYTES / MAG) * STRIDE + (k mod BYTES). Memory rows at index ROWS and above are never read.
- R4: Within a byte, bits [7:4] form the left pixel and bits [3:0] form the right pixel.
- R5: Each source pixel appears MAG times in a row, and each source line appears MAG times. A frame is 2*BYTES*MAG pixels wide and ROWS*MAG lines tall (512 x 256 by default).
- R6: For grey level i, g5 = 2*i + (i >> 3) and g6 = 2*g5 + (g5 >> 4). The pixel word is {g5 in bits [15:11], g6 in bits [10:5], g5 in bits [4:0]}.
- R7: `pix_sof_o` is 1 only on the first pixel of a frame. `pix_eol_o` is 1 exactly on the last pixel of every output line.
- R8: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the next cycle keeps `pix_valid_o` at 1 and holds the data word and both markers unchanged.
- R9: The flag clears in the cycle after the sink accepts the frame's last pixel. If `redraw_set_i` is 1 in that same cycle, the flag stays set and a further frame follows.
- R10: With `pix_ready_i` held at 1, the pixels of a frame are accepted on consecutive cycles. Exactly W*H-1 cycles separate the first acceptance from the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redraw_set_i | input | 1 | One-cycle request that sets the dirty flag |
| redraw_flag_o | output | 1 | Current dirty flag |
| ram_rd_en_o | output | 1 | Memory read strobe |
| ram_addr_o | output | AW (13 by default) | Memory byte address |
| ram_rd_data_i | input | 8 | Memory read data, valid one cycle after the strobe |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Sink ready |
| pix_data_o | output | 16 | RGB565 pixel word |
| pix_sof_o | output | 1 | First pixel of the frame |
| pix_eol_o | output | 1 | Last pixel of an output line |

## Verification
A wrong horizontal or vertical repeat counter shows up within one output line. It appears either as a misplaced end-of-line marker or as a pixel word taken from the wrong byte or nibble. A fetch counter that drifts from the pixel counter shows as a wrong address within one line, because every read address is compared in order. A stall or throughput fault shows as a changed word during a held cycle, or as a gap in an always-ready frame. A dirty-flag fault shows as reads while idle, as a missing follow-on frame, or as a flag that stays set after the final pixel.

// File: rtl/gsx_pkg.sv
package gsx_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    // One output beat as it sits in the output register.
    typedef struct packed {
        logic [15:0] rgb;
        logic        sof;
        logic        eol;
        logic        last;
    } pix_beat_t;

    // 4-bit grey level to 5-bit intensity: shift up, refill LSB from MSB.
    function automatic logic [4:0] grey_to_g5(input logic [3:0] lvl);
        return {lvl, lvl[3]};
    endfunction

    // 4-bit grey level to a neutral RGB565 word.
    function automatic logic [15:0] grey_to_rgb565(input logic [3:0] lvl);
        logic [4:0] g5;
        logic [5:0] g6;
        g5 = grey_to_g5(lvl);
        g6 = {g5, g5[4]};
        return {g5, g6, g5};
    endfunction

endpackage

// File: rtl/gsx_fetch.sv
// Read address generator: walks rows, vertical repeats and bytes in order.
module gsx_fetch #(
    parameter int BYTES  = 64,
    parameter int ROWS   = 64,
    parameter int MAG    = 4,
    parameter int STRIDE = 64,
    parameter int AW     = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          room_i,
    output logic          rd_en_o,
    output logic [AW-1:0] addr_o
);
    localparam int BW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int VW = (MAG   > 1) ? $clog2(MAG)   : 1;
    localparam int RW = (ROWS  > 1) ? $clog2(ROWS)  : 1;

    logic [BW-1:0] byte_q;
    logic [VW-1:0] vrep_q;
    logic [RW-1:0] row_q;
    logic          busy_q;
    logic          byte_wrap, vrep_wrap, row_wrap;

    assign byte_wrap = (byte_q == BW'(BYTES - 1));
    assign vrep_wrap = (vrep_q == VW'(MAG - 1));
    assign row_wrap  = (row_q  == RW'(ROWS - 1));

    assign rd_en_o = busy_q & room_i;
    assign addr_o  = AW'(row_q) * AW'(STRIDE) + AW'(byte_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            vrep_q <= '0;
            row_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            byte_q <= '0;
            vrep_q <= '0;
            row_q  <= '0;
            busy_q <= 1'b1;
        end else if (rd_en_o) begin
            byte_q <= byte_wrap ? '0 : byte_q + BW'(1);
            if (byte_wrap) begin
                vrep_q <= vrep_wrap ? '0 : vrep_q + VW'(1);
            end
            if (byte_wrap && vrep_wrap) begin
                row_q <= row_wrap ? '0 : row_q + RW'(1);
            end
            if (byte_wrap && vrep_wrap && row_wrap) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gsx_byte_fifo.sv
// Small byte queue absorbing the one-cycle read latency.
module gsx_byte_fifo #(
    parameter int DEPTH = 2,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] dout_o,
    output logic          nonempty_o,
    output logic [CW-1:0] count_o
);
    logic [DEPTH-1:0][DW-1:0] slots;
    logic [PW-1:0]            wp_q, rp_q;
    logic [CW-1:0]            cnt_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (push_i && (wp_q == PW'(g))) begin
                slot_q <= din_i;
            end
        end
        assign slots[g] = slot_q;
    end

    assign dout_o     = slots[rp_q];
    assign nonempty_o = (cnt_q != '0);
    assign count_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            end
            if (pop_i) begin
                rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
            end
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

endmodule

// File: rtl/gsx_pixel.sv
// Nibble selection, horizontal repeat, colour expansion and output register.
module gsx_pixel
    import gsx_pkg::*;
#(
    parameter int BYTES = 64,
    parameter int ROWS  = 64,
    parameter int MAG   = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic [7:0] head_i,
    input  logic      head_ok_i,
    input  logic      ready_i,
    output logic      pop_o,
    output logic      valid_o,
    output pix_beat_t beat_o,
    output logic      done_o
);
    localparam int LINES = ROWS * MAG;
    localparam int BW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int HW = (MAG   > 1) ? $clog2(MAG)   : 1;
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;

    logic          nib_q;
    logic [HW-1:0] hrep_q;
    logic [BW-1:0] col_q;
    logic [LW-1:0] line_q;
    logic          first_q;
    logic          ov_q;
    pix_beat_t     ob_q;

    logic          load, h_end, row_end, line_end;
    logic [3:0]    lvl;
    pix_beat_t     nb;

    assign load     = head_ok_i & (~ov_q | ready_i);
    assign h_end    = (hrep_q == HW'(MAG - 1));
    assign row_end  = (col_q  == BW'(BYTES - 1));
    assign line_end = (line_q == LW'(LINES - 1));
    assign lvl      = nib_q ? head_i[3:0] : head_i[7:4];

    always_comb begin
        nb.rgb  = grey_to_rgb565(lvl);
        nb.sof  = first_q;
        nb.eol  = h_end & nib_q & row_end;
        nb.last = h_end & nib_q & row_end & line_end;
    end

    assign pop_o   = load & h_end & nib_q;
    assign valid_o = ov_q;
    assign beat_o  = ob_q;
    assign done_o  = ov_q & ready_i & ob_q.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q   <= 1'b0;
            hrep_q  <= '0;
            col_q   <= '0;
            line_q  <= '0;
            first_q <= 1'b0;
            ov_q    <= 1'b0;
            ob_q    <= '0;
        end else begin
            if (start_i) begin
                nib_q   <= 1'b0;
                hrep_q  <= '0;
                col_q   <= '0;
                line_q  <= '0;
                first_q <= 1'b1;
            end else if (load) begin
                first_q <= 1'b0;
                hrep_q  <= h_end ? '0 : hrep_q + HW'(1);
                if (h_end) begin
                    nib_q <= ~nib_q;
                end
                if (h_end && nib_q) begin
                    col_q <= row_end ? '0 : col_q + BW'(1);
                end
                if (h_end && nib_q && row_end) begin
                    line_q <= line_end ? '0 : line_q + LW'(1);
                end
            end
            if (load) begin
                ov_q <= 1'b1;
                ob_q <= nb;
            end else if (ready_i) begin
                ov_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/grey_scanout.sv
module grey_scanout
    import gsx_pkg::*;
#(
    parameter int BYTES      = 64,
    parameter int ROWS       = 64,
    parameter int MAG        = 4,
    parameter int STRIDE     = 64,
    parameter int RAM_ROWS   = 80,
    parameter int FIFO_DEPTH = 2,
    localparam int AW        = $clog2(RAM_ROWS * STRIDE),
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redraw_set_i,
    output logic          redraw_flag_o,
    output logic          ram_rd_en_o,
    output logic [AW-1:0] ram_addr_o,
    input  logic [7:0]    ram_rd_data_i,
    output logic          pix_valid_o,
    input  logic          pix_ready_i,
    output logic [15:0]   pix_data_o,
    output logic          pix_sof_o,
    output logic          pix_eol_o
);
    scan_state_e state_q;
    logic        run_q;
    logic        dirty_q;
    logic        start;
    logic        inflight_q;
    logic        room;
    logic        rd_en;
    logic        pop;
    logic        head_ok;
    logic [7:0]  head;
    logic [CW-1:0] fifo_cnt;
    logic        frame_done;
    pix_beat_t   beat;

    assign run_q = (state_q == SCAN_RUN);
    assign start = (state_q == SCAN_IDLE) & dirty_q;
    assign room  = (32'(fifo_cnt) + 32'(inflight_q)) < FIFO_DEPTH;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SCAN_IDLE;
            dirty_q    <= 1'b0;
            inflight_q <= 1'b0;
        end else begin
            dirty_q    <= redraw_set_i | (dirty_q & ~frame_done);
            inflight_q <= rd_en;
            case (state_q)
                SCAN_IDLE: if (dirty_q)    state_q <= SCAN_RUN;
                SCAN_RUN:  if (frame_done) state_q <= SCAN_IDLE;
                default:                   state_q <= SCAN_IDLE;
            endcase
        end
    end

    gsx_fetch #(
        .BYTES (BYTES),
        .ROWS  (ROWS),
        .MAG   (MAG),
        .STRIDE(STRIDE),
        .AW    (AW)
    ) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .room_i (room),
        .rd_en_o(rd_en),
        .addr_o (ram_addr_o)
    );

    gsx_byte_fifo #(
        .DEPTH(FIFO_DEPTH),
        .DW   (8)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_i    (inflight_q),
        .din_i     (ram_rd_data_i),
        .pop_i     (pop),
        .dout_o    (head),
        .nonempty_o(head_ok),
        .count_o   (fifo_cnt)
    );

    gsx_pixel #(
        .BYTES(BYTES),
        .ROWS (ROWS),
        .MAG  (MAG)
    ) u_pixel (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .head_i   (head),
        .head_ok_i(head_ok),
        .ready_i  (pix_ready_i),
        .pop_o    (pop),
        .valid_o  (pix_valid_o),
        .beat_o   (beat),
        .done_o   (frame_done)
    );

    assign ram_rd_en_o   = rd_en;
    assign redraw_flag_o = dirty_q;
    assign pix_data_o    = beat.rgb;
    assign pix_sof_o     = beat.sof;
    assign pix_eol_o     = beat.eol;

endmodule

// File: rtl/gsx_scan_chk.sv
module gsx_scan_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        redraw_flag,
    input logic        rd_en,
    input logic        pix_valid,
    input logic        pix_ready,
    input logic [15:0] pix_data,
    input logic        pix_sof,
    input logic        pix_eol
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pix_valid && !rd_en && !redraw_flag));

    assert_no_pixel_without_flag_R2: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> redraw_flag);

    assert_no_read_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> run);

    assert_neutral_colour_R6: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_data[4:0] == pix_data[15:11]
                       && pix_data[10:5] == {pix_data[15:11], pix_data[15]}));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)
                                        && $stable(pix_sof) && $stable(pix_eol)));

    assert_flag_clears_on_last_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(redraw_flag) |-> $past(pix_valid && pix_ready && pix_eol));

endmodule

bind grey_scanout gsx_scan_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .redraw_flag(redraw_flag_o),
    .rd_en      (ram_rd_en_o),
    .pix_valid  (pix_valid_o),
    .pix_ready  (pix_ready_i),
    .pix_data   (pix_data_o),
    .pix_sof    (pix_sof_o),
    .pix_eol    (pix_eol_o)
);

// File: tb/grey_scanout_tb.sv
module grey_scanout_tb;
    localparam int BYTES    = 4;
    localparam int ROWS     = 3;
    localparam int MAG      = 2;
    localparam int STRIDE   = 5;
    localparam int RAM_ROWS = 4;
    localparam int AW       = $clog2(RAM_ROWS * STRIDE);
    localparam int MEMSZ    = RAM_ROWS * STRIDE;
    localparam int W        = 2 * BYTES * MAG;
    localparam int H        = ROWS * MAG;
    localparam int NPIX     = W * H;
    localparam int NREADS   = ROWS * MAG * BYTES;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_main = 1'b0;
    logic          set_auto = 1'b0;
    logic          redraw_set;
    logic          redraw_flag;
    logic          rd_en;
    logic [AW-1:0] addr;
    logic [7:0]    ram_q = 8'h00;
    logic          valid;
    logic          rdy = 1'b0;
    logic [15:0]   data;
    logic          sof, eol;

    logic [7:0] mem [MEMSZ];

    int checks = 0;
    int fails  = 0;
    int frames_done = 0;
    int ready_mode  = 0;
    bit arm_set_on_last = 1'b0;
    bit done = 1'b0;

    assign redraw_set = set_main | set_auto;

    always #2 clk = ~clk;

    grey_scanout #(
        .BYTES   (BYTES),
        .ROWS    (ROWS),
        .MAG     (MAG),
        .STRIDE  (STRIDE),
        .RAM_ROWS(RAM_ROWS)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .redraw_set_i (redraw_set),
        .redraw_flag_o(redraw_flag),
        .ram_rd_en_o  (rd_en),
        .ram_addr_o   (addr),
        .ram_rd_data_i(ram_q),
        .pix_valid_o  (valid),
        .pix_ready_i  (rdy),
        .pix_data_o   (data),
        .pix_sof_o    (sof),
        .pix_eol_o    (eol)
    );

    always @(posedge clk) if (rd_en) ram_q <= mem[addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rgb(input int lvl);
        int g5, g6;
        g5 = 2 * lvl + lvl / 8;
        g6 = 2 * g5 + g5 / 16;
        return g5 * 2048 + g6 * 32 + g5;
    endfunction

    // Stream monitor: drives ready, checks reads and accepted pixels.
    int  cyc = 0, pk = 0, rk = 0, sof_cyc = 0;
    bit  prev_stall = 1'b0;
    logic [15:0] prev_data;
    logic prev_sof, prev_eol;
    logic [7:0] lfsr = 8'hA5;

    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (ready_mode)
                0: rdy = 1'b1;
                1: rdy = lfsr[0] | lfsr[2];
                default: rdy = (cyc % 3 == 0);
            endcase
            if (prev_stall) begin
                // R8: held beat stays put
                check(valid && data == prev_data && sof == prev_sof && eol == prev_eol,
                      "R8 stall hold", int'(data), int'(prev_data));
            end
            if (rd_en) begin
                int line, row, byt, ea;
                line = rk / BYTES;
                row  = line / MAG;
                byt  = rk % BYTES;
                ea   = row * STRIDE + byt;
                check(rk < NREADS, "R2 read beyond frame", rk, NREADS - 1);
                check(int'(addr) == ea, "R3 read address", int'(addr), ea);
                rk++;
            end
            set_auto = 1'b0;
            if (valid && rdy) begin
                int line, x, p, byt, row, lvl, v;
                line = pk / W;
                x    = pk % W;
                p    = x / MAG;
                byt  = p / 2;
                row  = line / MAG;
                v    = int'(mem[row * STRIDE + byt]);
                lvl  = (p % 2 == 1) ? (v % 16) : (v / 16);   // R4 nibble order
                check(int'(data) == exp_rgb(lvl), "R4/R5/R6 pixel word", int'(data), exp_rgb(lvl));
                check(sof == (pk == 0), "R7 sof marker", int'(sof), int'(pk == 0));
                check(eol == (x == W - 1), "R7 eol marker", int'(eol), int'(x == W - 1));
                if (pk == 0) sof_cyc = cyc;
                if (pk == NPIX - 1) begin
                    check(rk == NREADS, "R3 read count", rk, NREADS);
                    if (ready_mode == 0)
                        check(cyc - sof_cyc == NPIX - 1, "R10 throughput", cyc - sof_cyc, NPIX - 1);
                    if (arm_set_on_last) begin
                        set_auto = 1'b1;
                        arm_set_on_last = 1'b0;
                    end
                    pk = 0;
                    rk = 0;
                    frames_done++;
                end else begin
                    pk++;
                end
            end
            prev_stall = valid && !rdy;
            prev_data  = data;
            prev_sof   = sof;
            prev_eol   = eol;
        end
    end

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!valid && !rd_en, "R2 idle quiet", int'({valid, rd_en}), 0);
        end
    endtask

    task automatic request_frame();
        @(negedge clk);
        set_main = 1'b1;
        @(negedge clk);
        set_main = 1'b0;
        check(redraw_flag == 1'b1, "R2 flag set", int'(redraw_flag), 1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < MEMSZ; a++) mem[a] = 8'(((2 * a) % 16) * 16 + (2 * a + 1) % 16);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!valid && !rd_en && !redraw_flag, "R1 reset state",
              int'({valid, rd_en, redraw_flag}), 0);
        idle_check(20);

        // Frame A: always ready
        ready_mode = 0;
        request_frame();
        wait (frames_done == 1);
        @(negedge clk);
        check(redraw_flag == 1'b0, "R9 flag cleared", int'(redraw_flag), 0);
        idle_check(30);

        // Frame B with irregular ready, re-requested on its last pixel
        for (int a = 0; a < MEMSZ; a++) mem[a] = 8'((a * 37 + 11) % 256);
        ready_mode = 1;
        arm_set_on_last = 1'b1;
        request_frame();
        wait (frames_done == 1 + 1);
        @(negedge clk);
        check(redraw_flag == 1'b1, "R9 set on last keeps flag", int'(redraw_flag), 1);
        ready_mode = 2;
        wait (frames_done == 3);
        @(negedge clk);
        check(redraw_flag == 1'b0, "R9 flag cleared after follow-on", int'(redraw_flag), 0);
        idle_check(30);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=3 frames", frames_done);
            finish_run();
        end
    end

endmodule